// File: doc/BRIEF.md
# Hub Status Change Interrupt Responder

This block answers polls on a hub's interrupt endpoint with the set of sources whose status has changed. There are five sources: the hub itself and four downstream ports. A change event on any source is first latched in a sticky pending mask, so an event that arrives mid-frame is never lost. Once per frame, at the end-of-frame sample point (the EOF2 strobe), the pending mask is folded into a reported bitmap, which is used for polls in the following frame.

Each IN token addressed to the endpoint produces one response in the next cycle. The response is either a NAK or one data byte carrying the reported bitmap. A reported bit stays set, and is returned on every poll, until the host acknowledges it with a clear-feature request for that source. While the hub is not configured, every poll is answered with NAK.

Serial encoding, CRC and handshake timing on the wire belong to other blocks.

Top module: `hsc_intr_responder`

## Requirements
- R1: After reset, the pending mask and the reported bitmap are empty, and no response is issued until a token arrives.
- R2: A change event is held in the pending mask and is not reported before the next EOF2 strobe.
- R3: On an EOF2 strobe, pending changes are merged into the reported bitmap and the pending mask empties. Bit 0 is the hub and bit k is port k (k = 1 to 4).
- R4: Bits 7 to 5 of the response byte are always 0.
- R5: A token that finds an all-zero reported bitmap is answered with NAK (rsp_data_o = 0, byte 0).
- R6: A token that finds any reported bit set is answered with data (rsp_data_o = 1), and the byte holds the full bitmap.
- R7: Reported bits persist across any number of polls and EOF2 strobes until they are cleared.
- R8: A bit set in clr_mask_i clears both the pending and the reported bit of that source in the same cycle. Other sources are not affected.
- R9: While cfg_i is 0, every token is answered with NAK, whatever is pending or reported.
- R10: rsp_vld_o is high for exactly the one cycle after each token cycle.
- R11: An event that coincides with a clear of the same source is kept as pending. An event that coincides with EOF2 waits for the following EOF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_evt_i | input | 5 | One-cycle change events; bit 0 hub, bits 1-4 ports |
| eof2_i | input | 1 | End-of-frame sample strobe |
| cfg_i | input | 1 | Hub configured |
| in_tok_i | input | 1 | IN token to the interrupt endpoint |
| clr_mask_i | input | 5 | Clear-feature acknowledgement per source |
| rsp_vld_o | output | 1 | Response present |
| rsp_data_o | output | 1 | 1 = data byte, 0 = NAK |
| rsp_byte_o | output | 8 | Response payload |

## Verification
The bench sweeps all 32 event masks. For each mask it checks three things:
- A poll before EOF2 still NAKs. A design that reported events directly would answer with data too early.
- The byte is reported on repeated polls and across later frames. A design that cleared bits on read or on sampling would lose them.
- Only the requested sources are cleared.

Collisions get their own checks: an event in the same cycle as a clear, and an event in the same cycle as EOF2. A wrong priority there either drops the event or reports it one frame early. The unconfigured case checks that a full bitmap still gives NAK, and that the bitmap appears once the hub is configured.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    localparam int unsigned NUM_PORTS = 4;
    localparam int unsigned NSRC      = NUM_PORTS + 1;
    localparam int unsigned BYTE_W    = 8;

    typedef logic [NSRC-1:0] src_mask_t;

    typedef struct packed {
        logic              vld;
        logic              is_data;
        logic [BYTE_W-1:0] payload;
    } rsp_t;

    function automatic logic [BYTE_W-1:0] pack_bitmap(input src_mask_t m);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[NSRC-1:0] = m;
        return r;
    endfunction
endpackage

// File: rtl/hsc_pending.sv
module hsc_pending
    import hsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t evt,
    input  src_mask_t clr,
    input  logic      eof2,
    output src_mask_t pend
);
    always_ff @(posedge clk) begin
        if (rst)       pend <= '0;
        else if (eof2) pend <= evt;
        else           pend <= (pend & ~clr) | evt;
    end

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~evt) != '0) |=> ((pend & $past(clr & ~evt)) == '0));
    // R11
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/hsc_sampler.sv
module hsc_sampler
    import hsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      eof2,
    input  src_mask_t pend,
    input  src_mask_t clr,
    output src_mask_t rpt
);
    always_ff @(posedge clk) begin
        if (rst)       rpt <= '0;
        else if (eof2) rpt <= (rpt | pend) & ~clr;
        else           rpt <= rpt & ~clr;
    end

    // R7
    rpt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!eof2 && clr == '0) |=> $stable(rpt));
    // R2
    rpt_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !eof2 |=> ((rpt & ~$past(rpt)) == '0));
endmodule

// File: rtl/hsc_responder.sv
module hsc_responder
    import hsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tok,
    input  logic      cfg,
    input  src_mask_t rpt,
    output rsp_t      rsp
);
    logic give_data;
    assign give_data = cfg && (rpt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.vld     <= tok;
            rsp.is_data <= tok && give_data;
            rsp.payload <= (tok && give_data) ? pack_bitmap(rpt) : '0;
        end
    end

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp.payload[BYTE_W-1:NSRC] == '0);
    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        tok |=> rsp.vld);
    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tok |=> !rsp.vld && !rsp.is_data);
endmodule

// File: rtl/hsc_intr_responder.sv
module hsc_intr_responder
    import hsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   chg_evt_i,
    input  logic              eof2_i,
    input  logic              cfg_i,
    input  logic              in_tok_i,
    input  logic [NSRC-1:0]   clr_mask_i,
    output logic              rsp_vld_o,
    output logic              rsp_data_o,
    output logic [BYTE_W-1:0] rsp_byte_o
);
    src_mask_t pend, rpt;
    rsp_t      rsp;

    hsc_pending i_pend (
        .clk(clk), .rst(rst), .evt(chg_evt_i), .clr(clr_mask_i),
        .eof2(eof2_i), .pend(pend)
    );

    hsc_sampler i_samp (
        .clk(clk), .rst(rst), .eof2(eof2_i), .pend(pend),
        .clr(clr_mask_i), .rpt(rpt)
    );

    hsc_responder i_resp (
        .clk(clk), .rst(rst), .tok(in_tok_i), .cfg(cfg_i),
        .rpt(rpt), .rsp(rsp)
    );

    assign rsp_vld_o  = rsp.vld;
    assign rsp_data_o = rsp.is_data;
    assign rsp_byte_o = rsp.payload;

    // R9
    unconfig_nak_chk: assert property (@(posedge clk) disable iff (rst)
        (in_tok_i && !cfg_i) |=> (rsp_vld_o && !rsp_data_o));
    // R5
    empty_nak_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o && !rsp_data_o |-> rsp_byte_o == '0);
endmodule

// File: tb/test_hsc_intr_responder.sv
module test_hsc_intr_responder;
    logic       clk = 0;
    logic       rst = 1;
    logic [4:0] evt = '0;
    logic       eof2 = 0;
    logic       cfg = 0;
    logic       tok = 0;
    logic [4:0] clr = '0;
    logic       rsp_vld, rsp_data;
    logic [7:0] rsp_byte;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hsc_intr_responder i_hsc_intr_responder (
        .clk(clk), .rst(rst), .chg_evt_i(evt), .eof2_i(eof2), .cfg_i(cfg),
        .in_tok_i(tok), .clr_mask_i(clr), .rsp_vld_o(rsp_vld),
        .rsp_data_o(rsp_data), .rsp_byte_o(rsp_byte)
    );

    task automatic check(string req, logic v, logic d, logic [7:0] b);
        n_chk++;
        if (rsp_vld !== v || rsp_data !== d || rsp_byte !== b) begin
            n_fail++;
            $display("FAIL %s: got vld=%b data=%b byte=%02h, expected vld=%b data=%b byte=%02h",
                     req, rsp_vld, rsp_data, rsp_byte, v, d, b);
        end
    endtask

    task automatic cyc(logic [4:0] e, logic f, logic [4:0] c, logic t);
        @(negedge clk);
        evt = e; eof2 = f; clr = c; tok = t;
        @(negedge clk);
        evt = '0; eof2 = 0; clr = '0; tok = 0;
    endtask

    task automatic poll(string req, logic [4:0] m);
        cyc('0, 0, '0, 1);
        check(req, 1'b1, m != 0, {3'b000, m});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset idle", 1'b0, 1'b0, 8'h00);
        rst = 0;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 1'b0, 8'h00);
        cfg = 1;
        poll("R1 empty after reset", 5'h00);
        @(negedge clk);
        check("R10 single-cycle response", 1'b0, 1'b0, 8'h00);

        for (int m = 0; m < 32; m++) begin
            logic [4:0] mk, c;
            mk = m[4:0];
            c  = mk ^ 5'h0B;
            cyc(mk, 0, '0, 0);
            poll("R2 not reported before EOF2", 5'h00);
            cyc('0, 1, '0, 0);
            poll(mk != 0 ? "R6 R3 R4 data bitmap" : "R5 empty NAK", mk);
            poll("R7 repeated poll", mk);
            cyc('0, 1, '0, 0);
            poll("R7 persists across EOF2", mk);
            cyc('0, 0, c, 0);
            poll("R8 selective clear", mk & ~c);
            cyc('0, 0, 5'h1F, 0);
            cyc('0, 1, '0, 0);
            poll("R8 full clear", 5'h00);
        end

        // R9
        cfg = 0;
        cyc(5'h1F, 0, '0, 0);
        cyc('0, 1, '0, 0);
        poll("R9 unconfigured NAK", 5'h00);
        cfg = 1;
        poll("R9 reported once configured", 5'h1F);
        cyc('0, 0, 5'h1F, 0);

        // R8: pending bit cleared before sampling
        cyc(5'h02, 0, '0, 0);
        cyc('0, 0, 5'h02, 0);
        cyc('0, 1, '0, 0);
        poll("R8 pending cleared", 5'h00);

        // R11: event colliding with clear
        cyc(5'h04, 0, 5'h04, 0);
        cyc('0, 1, '0, 0);
        poll("R11 event with clear kept", 5'h04);
        cyc('0, 0, 5'h1F, 0);

        // R11: event colliding with EOF2
        cyc(5'h08, 1, '0, 0);
        poll("R11 event with EOF2 deferred", 5'h00);
        cyc('0, 1, '0, 0);
        poll("R11 event with EOF2 next frame", 5'h08);
        @(negedge clk);
        check("R10 response drops", 1'b0, 1'b0, 8'h00);

        done = 1;
        summary();
        $finish;
    end
endmodule